// File: doc/BRIEF.md
# Integer Compare Flag Generator

This unit compares two entries of a small bank of 64-bit registers and reports the outcome as a 32-bit status word. The four condition flags (negative, zero, carry, overflow) sit in the top nibble. The flags come from subtracting the second operand from the first. Two widths are offered. The narrow compare works on the low 32 bits of each register. The wide compare treats each full register as a 64-bit integer whose upper half is the most significant word.

A compare is requested with a 32-bit instruction word on a valid/ready command channel. The instruction word carries the two source indices and a sub-opcode that selects the compare width. The command is taken on any clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low during reset and rises at the first clock edge after reset is released. From then on it stays high, so the unit never applies back-pressure and accepts one command per cycle. A requester that holds `cmd_valid` high issues a new compare on every edge. The result leaves on plain pins: a one-cycle done pulse, an illegal-operation pulse, and the registered status word. The status word keeps its value until the next accepted command.

The register bank is held inside the unit. It is loaded through a simple write strobe so that the compare operands can be set up. A compare accepted in the same cycle as a write reads the contents from before that write.

Top module: `cmpflag_unit`

## Requirements
- R1: While reset is asserted and directly after it, `res_done`, `res_illegal` and `res_status` are zero. Every register in the bank reads as zero until it is written.
- R2: Inside `cmd_instr`, bits 19..16 give the first source index and bits 3..0 give the second. Bits 7..5 are the sub-opcode: 4 selects the 32-bit compare and 5 selects the 64-bit compare. All other instruction bits have no effect.
- R3: In the status word, N is bit 31, Z is bit 30, C is bit 29 and V is bit 28. Bits 27..0 are always zero.
- R4: The difference is the first source minus the second, taken at the compare width. Z is set when the difference is zero. N is set when the top bit of the difference is one.
- R5: Let a, b and r be the signs of the first source, the second source and the difference. C is set when (a is negative and b is not) or (a is negative and r is not) or (neither b nor r is negative). This is the no-borrow rule, so C is set exactly when the first source is unsigned greater than or equal to the second.
- R6: V is set when the subtraction overflows as a signed operation. That happens when a is negative, b is not and r is not, or when a is not negative, b is and r is.
- R7: The 32-bit compare uses only bits 31..0 of each register. The upper halves have no effect on its flags.
- R8: The 64-bit compare uses the whole register, with bits 63..32 as the most significant word.
- R9: A sub-opcode other than 4 or 5 still produces the done pulse. Together with it, `res_illegal` pulses high and the status word becomes all zero.
- R10: `res_done` is high for exactly the one cycle after each accepted command and low otherwise. `res_status` changes only after an accepted command.
- R11: A write with `wr_en` high stores `wr_data` into register `wr_idx` at the clock edge. A compare accepted at that same edge sees the old contents.
- R12: `cmd_ready` is low in reset and high from the first clock edge after reset is released. A command is taken only when `cmd_valid` and `cmd_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Compare request present |
| cmd_ready | output | 1 | Unit can take a request |
| cmd_instr | input | 32 | Instruction word with source indices and sub-opcode |
| wr_en | input | 1 | Register bank write strobe |
| wr_idx | input | 4 | Register bank write index |
| wr_data | input | 64 | Register bank write data |
| res_done | output | 1 | One-cycle pulse: result valid |
| res_illegal | output | 1 | One-cycle pulse with done: unknown sub-opcode |
| res_status | output | 32 | Status word holding NZCV in bits 31..28 |

## Verification
The hardest case to reach from the ports is the signed-overflow corner. There the sign of the difference disagrees with the true ordering, and N, C and V must split three ways. The bench loads operands at the most-negative and most-positive extremes and at -1, so that both overflow directions occur in the narrow and in the wide compare. It also loads register pairs that share low halves but differ above. The stimulus then issues both compare widths against the same pair. A further directed step writes a register and compares it in the same cycle, to expose the ordering between write and read. The rest comes from a random mix of writes and compares with arbitrary sub-opcodes, checked every clock against a behavioural model built on wide signed arithmetic and unsigned comparison.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

  localparam int INSTR_W   = 32;
  localparam int SRC_A_LSB = 16;
  localparam int SRC_B_LSB = 0;
  localparam int SUBOP_LSB = 5;
  localparam int SUBOP_W   = 3;
  localparam int STATUS_W  = 32;
  localparam int FLAG_W    = 4;

  localparam logic [SUBOP_W-1:0] SUBOP_CMP_NARROW = 3'd4;
  localparam logic [SUBOP_W-1:0] SUBOP_CMP_WIDE   = 3'd5;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_WIDE   = 2'd2
  } cmp_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Flags occupy the top nibble; everything below reads zero.
  function automatic logic [STATUS_W-1:0] pack_status(nzcv_t f);
    return {f, {(STATUS_W-FLAG_W){1'b0}}};
  endfunction

  // Mask of instruction bits that the decoder looks at.
  function automatic logic [INSTR_W-1:0] used_mask(int idx_w);
    logic [INSTR_W-1:0] m;
    m = '0;
    for (int i = 0; i < idx_w; i++) begin
      m[SRC_A_LSB + i] = 1'b1;
      m[SRC_B_LSB + i] = 1'b1;
    end
    for (int i = 0; i < SUBOP_W; i++) m[SUBOP_LSB + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/cmpflag_decode.sv
module cmpflag_decode
  import cmpflag_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   idx_a,
  output logic [IDX_W-1:0]   idx_b,
  output cmp_mode_e          mode
);

  localparam logic [INSTR_W-1:0] USED = used_mask(IDX_W);

  logic [SUBOP_W-1:0] subop;
  logic               unused_instr_bits;

  assign unused_instr_bits = ^(instr & ~USED);
  assign subop = instr[SUBOP_LSB +: SUBOP_W];

  always_comb begin
    idx_a = instr[SRC_A_LSB +: IDX_W];
    idx_b = instr[SRC_B_LSB +: IDX_W];
    case (subop)
      SUBOP_CMP_NARROW: mode = MODE_NARROW;
      SUBOP_CMP_WIDE:   mode = MODE_WIDE;
      default:          mode = MODE_NONE;
    endcase
  end

endmodule

// File: rtl/cmpflag_regfile.sv
module cmpflag_regfile #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_en && (int'(wr_idx) < NUM_REGS)) begin
      bank_q[wr_idx] <= wr_data;
    end
  end

  // Reads are combinational from the stored state: a same-edge write is not seen.
  assign rd_a = (int'(rd_a_idx) < NUM_REGS) ? bank_q[rd_a_idx] : '0;
  assign rd_b = (int'(rd_b_idx) < NUM_REGS) ? bank_q[rd_b_idx] : '0;

endmodule

// File: rtl/cmpflag_sub.sv
module cmpflag_sub
  import cmpflag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output nzcv_t        flags
);

  logic [W-1:0] diff;
  logic         sa, sb, sr;

  assign diff = opa - opb;
  assign sa   = opa[W-1];
  assign sb   = opb[W-1];
  assign sr   = diff[W-1];

  always_comb begin
    flags.n = sr;
    flags.z = (diff == '0);
    // Carry means no borrow occurred.
    flags.c = (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
    // Signed overflow: operand signs differ and the result sign follows b.
    flags.v = (sa & ~sb & ~sr) | (~sa & sb & sr);
  end

endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [INSTR_W-1:0]          cmd_instr,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        res_done,
  output logic                        res_illegal,
  output logic [STATUS_W-1:0]         res_status
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int HALF_W = DATA_W / 2;

  logic [IDX_W-1:0]  idx_a, idx_b;
  cmp_mode_e         mode;
  logic [DATA_W-1:0] opa, opb;
  nzcv_t             flags_narrow, flags_wide, flags_sel;
  logic              ready_q, done_q, illegal_q;
  logic [STATUS_W-1:0] status_q;
  logic              accept;

  cmpflag_decode #(.IDX_W(IDX_W)) u_decode (
    .instr (cmd_instr),
    .idx_a (idx_a),
    .idx_b (idx_b),
    .mode  (mode)
  );

  cmpflag_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_a_idx (idx_a),
    .rd_b_idx (idx_b),
    .rd_a     (opa),
    .rd_b     (opb)
  );

  cmpflag_sub #(.W(HALF_W)) u_sub_narrow (
    .opa   (opa[HALF_W-1:0]),
    .opb   (opb[HALF_W-1:0]),
    .flags (flags_narrow)
  );

  cmpflag_sub #(.W(DATA_W)) u_sub_wide (
    .opa   (opa),
    .opb   (opb),
    .flags (flags_wide)
  );

  assign accept = cmd_valid & ready_q;

  always_comb begin
    case (mode)
      MODE_NARROW: flags_sel = flags_narrow;
      MODE_WIDE:   flags_sel = flags_wide;
      default:     flags_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      status_q  <= '0;
    end else begin
      ready_q   <= 1'b1;
      done_q    <= accept;
      illegal_q <= accept && (mode == MODE_NONE);
      if (accept) status_q <= pack_status(flags_sel);
    end
  end

  assign cmd_ready   = ready_q;
  assign res_done    = done_q;
  assign res_illegal = illegal_q;
  assign res_status  = status_q;

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_done); // R10
  AST_NO_DONE_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !res_done); // R10
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(res_status)); // R10
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[STATUS_W-FLAG_W-1:0] == '0); // R3
  AST_ILLEGAL_ZERO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_done && res_status == '0)); // R9
  AST_EQUAL_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_status[STATUS_W-2]) |-> res_status[STATUS_W-3]); // R5
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[STATUS_W-2] |-> !res_status[STATUS_W-1]); // R4
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cmd_ready); // R12

endmodule

// File: tb/cmpflag_unit_bench.sv
`timescale 1ns/1ps
module cmpflag_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_instr = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        res_done, res_illegal;
  logic [31:0] res_status;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string phase = "R1";

  // behavioural reference state
  logic [63:0] m_bank [16];
  logic        m_ready = 1'b0, m_done = 1'b0, m_illegal = 1'b0;
  logic [31:0] m_status = '0;

  always #2 clk = ~clk;

  cmpflag_unit u_cmpflag_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_instr(cmd_instr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .res_done(res_done), .res_illegal(res_illegal), .res_status(res_status)
  );

  function automatic logic [31:0] ref_flags(logic [63:0] a, logic [63:0] b, bit wide);
    logic n, z, c, v;
    if (wide) begin
      logic [64:0] sd;
      logic [63:0] r;
      r  = a - b;
      sd = {a[63], a} - {b[63], b};
      n = r[63]; z = (r == 0); c = (a >= b); v = (sd[64] != sd[63]);
    end else begin
      logic [32:0] sd;
      logic [31:0] r;
      r  = a[31:0] - b[31:0];
      sd = {a[31], a[31:0]} - {b[31], b[31:0]};
      n = r[31]; z = (r == 0); c = (a[31:0] >= b[31:0]); v = (sd[32] != sd[31]);
    end
    return {n, z, c, v, 28'h0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_bank[i] = '0;
      m_ready = 0; m_done = 0; m_illegal = 0; m_status = '0;
    end else begin
      m_done = cmd_valid && m_ready;
      m_illegal = 0;
      if (m_done) begin
        logic [2:0] sop;
        sop = cmd_instr[7:5];
        if (sop == 3'd4 || sop == 3'd5)
          m_status = ref_flags(m_bank[cmd_instr[19:16]], m_bank[cmd_instr[3:0]], sop == 3'd5);
        else begin
          m_status = '0; m_illegal = 1;
        end
      end
      if (wr_en) m_bank[wr_idx] = wr_data;
      m_ready = 1;
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      check(phase, "cmd_ready", {63'd0, cmd_ready}, {63'd0, m_ready});
      check(phase, "res_done", {63'd0, res_done}, {63'd0, m_done});
      check(phase, "res_illegal", {63'd0, res_illegal}, {63'd0, m_illegal});
      check(phase, "res_status", {32'd0, res_status}, {32'd0, m_status});
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [31:0] mk(logic [3:0] a, logic [3:0] b, logic [2:0] sop);
    logic [31:0] w;
    w = '0;
    w[19:16] = a; w[3:0] = b; w[7:5] = sop;
    return w;
  endfunction

  task automatic cmp(string req, input logic [31:0] ins, input logic [31:0] exp, input bit ill);
    @(negedge clk);
    cmd_valid = 1; cmd_instr = ins;
    @(negedge clk);
    cmd_valid = 0;
    check(req, "done pulse", {63'd0, res_done}, 64'd1);
    check(req, "illegal", {63'd0, res_illegal}, {63'd0, ill});
    check(req, "status", {32'd0, res_status}, {32'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset done", {63'd0, res_done}, 64'd0);
    check("R1", "reset status", {32'd0, res_status}, 64'd0);
    check("R12", "ready in reset", {63'd0, cmd_ready}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R12", "ready after reset", {63'd0, cmd_ready}, 64'd1);
    // R1: untouched registers read zero, equal -> Z and C
    cmp("R1", mk(4'd3, 4'd9, 3'd4), 32'h6000_0000, 0);

    phase = "R4";
    wr(4'd1, 64'd5); wr(4'd2, 64'd3);
    cmp("R4", mk(4'd1, 4'd2, 3'd4), 32'h2000_0000, 0);
    cmp("R4", mk(4'd2, 4'd1, 3'd4), 32'h8000_0000, 0);
    phase = "R6";
    wr(4'd3, 64'h0000_0000_8000_0000); wr(4'd4, 64'd1);
    cmp("R6", mk(4'd3, 4'd4, 3'd4), 32'h3000_0000, 0);
    wr(4'd5, 64'h0000_0000_7fff_ffff); wr(4'd6, 64'h0000_0000_ffff_ffff);
    cmp("R6", mk(4'd5, 4'd6, 3'd4), 32'h9000_0000, 0);
    wr(4'd7, 64'h8000_0000_0000_0000);
    cmp("R6", mk(4'd7, 4'd4, 3'd5), 32'h3000_0000, 0);
    phase = "R5";
    cmp("R5", mk(4'd4, 4'd6, 3'd4), 32'h0000_0000, 0);
    // R7: same low halves, different upper halves
    phase = "R7";
    wr(4'd8, 64'h1234_0000_0000_0042); wr(4'd9, 64'h0000_0001_0000_0042);
    cmp("R7", mk(4'd8, 4'd9, 3'd4), 32'h6000_0000, 0);
    cmp("R8", mk(4'd8, 4'd9, 3'd5), 32'h2000_0000, 0);
    // R8: upper word is the most significant word
    phase = "R8";
    wr(4'd10, 64'h0000_0001_0000_0000); wr(4'd11, 64'h0000_0000_ffff_ffff);
    cmp("R8", mk(4'd10, 4'd11, 3'd5), 32'h2000_0000, 0);
    cmp("R8", mk(4'd11, 4'd10, 3'd5), 32'h8000_0000, 0);
    // R9: unknown sub-opcodes
    phase = "R9";
    cmp("R9", mk(4'd1, 4'd2, 3'd0), 32'h0, 1);
    cmp("R9", mk(4'd1, 4'd2, 3'd6), 32'h0, 1);
    // R2: unused instruction bits ignored
    phase = "R2";
    cmp("R2", mk(4'd1, 4'd2, 3'd4) | 32'hfff0_ff10, 32'h2000_0000, 0);
    // R11: same-edge write is not seen
    phase = "R11";
    wr(4'd12, 64'd77); wr(4'd13, 64'd77);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd12; wr_data = 64'd10;
    cmd_valid = 1; cmd_instr = mk(4'd12, 4'd13, 3'd5);
    @(negedge clk);
    wr_en = 0; cmd_valid = 0;
    check("R11", "old value seen", {32'd0, res_status}, 64'h6000_0000);
    cmp("R11", mk(4'd12, 4'd13, 3'd5), 32'h8000_0000, 0);
    // R10: done drops, status holds
    phase = "R10";
    @(negedge clk);
    check("R10", "done one cycle", {63'd0, res_done}, 64'd0);
    check("R10", "status held", {32'd0, res_status}, 64'h8000_0000);
    // back-to-back commands, then random mix
    phase = "R12";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en = $urandom_range(0, 1);
      wr_idx = 4'($urandom);
      case ($urandom_range(0, 3))
        0: wr_data = 64'h8000_0000_0000_0000;
        1: wr_data = {32'($urandom), 32'h8000_0000};
        2: wr_data = 64'hffff_ffff_ffff_ffff;
        default: wr_data = {32'($urandom), 32'($urandom)};
      endcase
      cmd_valid = $urandom_range(0, 2) != 0;
      cmd_instr = 32'($urandom);
      if ($urandom_range(0, 3) != 0) cmd_instr[7:5] = $urandom_range(0, 1) ? 3'd4 : 3'd5;
    end
    @(negedge clk);
    cmd_valid = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule